// File: doc/BRIEF.md
# Pulse-Skip Segment Scaling Controller

This block is the digital control core of a switched-capacitor step-down converter. Analog comparators supply level flags: output above its upper limit, output below its lower limit, output shorted, supply under-voltage and over-temperature. An enable input is also present. Each clock period is one charge cycle. In every cycle the block decides whether the power stage switches or skips. It also chooses how much of each power switch to turn on: a quarter, a half or all of it.

Regulation works by pulse skipping. When the upper flag is seen, switching stops and the block waits in a skip state. When the lower flag is seen, switching restarts at quarter strength. If regulation takes too many charge cycles, strength grows to half and then to the full switch. While the short flag is set, only one pulse in sixteen reaches the power stage. A missing enable or any fault holds every switch off, which isolates the output from the supply.

Top module: `pss_ctrl`

## Requirements
- R1: While switching and not faulted, a synchronized upper-limit flag moves the block to the skip state on the next edge. In the skip state `active_o` is 0 and `seg_o` is 00.
- R2: From the skip state, a synchronized lower-limit flag without the upper-limit flag restarts switching on the next edge. The restart always uses quarter strength (`seg_o` = 01) and clears the charge-cycle count.
- R3: After 3 charge cycles at quarter strength without the upper-limit flag, the strength rises to half (`seg_o` = 10).
- R4: After a further 7 charge cycles at half strength without regulation, the strength rises to full (`seg_o` = 11). It stays full until the next skip.
- R5: While the synchronized short flag is set, `active_o` is 1 only in cycles where a free-running 4-bit counter reads zero. That counter is cleared by reset and advances every clock, so at most one cycle in sixteen is active.
- R6: When enable is low, or the under-voltage or over-temperature flag is set (after synchronization), the block enters the off state on the next edge and drives 0 / 00. When the fault clears, the block moves to the skip state and waits there for the lower-limit flag.
- R7: `seg_o` encodes strength as 00 off, 01 quarter, 10 half and 11 full. `seg_o` is 00 exactly when `active_o` is 0.
- R8: Every input passes through two flip-flops. A change on a level flag or on enable reaches the outputs after the third rising edge. A change on the short flag reaches the outputs after the second rising edge.
- R9: While `rst_ni` is low, the block is in the off state with `active_o` = 0, `seg_o` = 00, and its counters at zero.
- R10: The upper-limit flag has priority over the lower-limit flag. With both set, the block neither restarts from skip nor keeps switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Charge-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| uv_i | input | 1 | Supply under-voltage flag |
| ot_i | input | 1 | Over-temperature flag |
| above_i | input | 1 | Output above upper limit |
| below_i | input | 1 | Output below lower limit |
| short_i | input | 1 | Output short flag |
| active_o | output | 1 | Switching strobe for this charge cycle |
| seg_o | output | 2 | Segment enable code: 00 off, 01 quarter, 10 half, 11 full |

## Verification
The assertions assume only that every flag is a level that is sampled after the two-flop synchronizer. They assume that above and below may be set together, and that faults may arrive in any state. They make no assumption of comparator hysteresis. The random stimulus holds each flag for a random run of cycles, so long runs without the upper flag occur and reach full strength. Directed phases add cases the random weights rarely produce: long short-circuit runs, both limit flags set together, faults during full-strength switching, and single-cycle flag pulses.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    SEG_OFF  = 2'b00,
    SEG_QTR  = 2'b01,
    SEG_HALF = 2'b10,
    SEG_FULL = 2'b11
  } seg_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SKIP = 2'd1,
    ST_RUN  = 2'd2
  } state_t;

  // synchronized input vector bit positions
  localparam int unsigned IN_EN    = 0;
  localparam int unsigned IN_UV    = 1;
  localparam int unsigned IN_OT    = 2;
  localparam int unsigned IN_ABOVE = 3;
  localparam int unsigned IN_BELOW = 4;
  localparam int unsigned IN_SHORT = 5;
  localparam int unsigned IN_W     = 6;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pss_escalate.sv
module pss_escalate
  import pss_pkg::*;
#(
  parameter int unsigned QTR_CYC  = 3,
  parameter int unsigned HALF_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output seg_t level_o
);
  localparam int unsigned SAT   = QTR_CYC + HALF_CYC;
  localparam int unsigned CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(QTR_CYC);

  logic [CNT_W-1:0] cyc_q;

  // count charge cycles since restart; held at zero outside run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
    end else if (cyc_q != CNT_SAT) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  always_comb begin
    if (cyc_q < CNT_HALF)     level_o = SEG_QTR;
    else if (cyc_q < CNT_SAT) level_o = SEG_HALF;
    else                      level_o = SEG_FULL;
  end
endmodule

// File: rtl/pss_short_gate.sv
module pss_short_gate #(
  parameter int unsigned PERIOD_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic allow_o
);
  logic [PERIOD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign allow_o = (cnt_q == '0);
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QTR_CYC     = 3,
  parameter int unsigned HALF_CYC    = 7,
  parameter int unsigned SHORT_W     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       above_i,
  input  logic       below_i,
  input  logic       short_i,
  output logic       active_o,
  output logic [1:0] seg_o
);
  logic [IN_W-1:0] raw, syn;
  logic   fault, s_above, s_below, s_short, allow;
  state_t state_q, state_d;
  seg_t   level;

  assign raw = {short_i, below_i, above_i, ot_i, uv_i, en_i};

  pss_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign fault   = !syn[IN_EN] | syn[IN_UV] | syn[IN_OT];
  assign s_above = syn[IN_ABOVE];
  assign s_below = syn[IN_BELOW];
  assign s_short = syn[IN_SHORT];

  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_SKIP;
        ST_SKIP: if (s_below && !s_above) state_d = ST_RUN;
        ST_RUN:  if (s_above) state_d = ST_SKIP;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  pss_escalate #(.QTR_CYC(QTR_CYC), .HALF_CYC(HALF_CYC)) i_escalate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN),
    .level_o(level)
  );

  pss_short_gate #(.PERIOD_W(SHORT_W)) i_short_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .allow_o(allow)
  );

  assign active_o = (state_q == ST_RUN) && (!s_short || allow);
  assign seg_o    = active_o ? level : SEG_OFF;
endmodule

// File: rtl/pss_ctrl_chk.sv
module pss_ctrl_chk
  import pss_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       active_o,
  input logic [1:0] seg_o,
  input state_t     state_q,
  input seg_t       level,
  input logic       fault,
  input logic       s_above,
  input logic       s_below,
  input logic       s_short,
  input logic       allow
);
  // R7
  seg_zero_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> seg_o == 2'b00);
  // R7
  seg_nonzero_when_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> seg_o != 2'b00);
  // R1
  skip_on_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && s_above && !fault) |=> state_q == ST_SKIP);
  // R2
  restart_quarter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && s_below && !s_above && !fault) |=>
      (state_q == ST_RUN && level == SEG_QTR));
  // R10
  above_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && s_above) |=> state_q != ST_RUN);
  // R6
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (state_q == ST_OFF && !active_o));
  // R5
  short_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && s_short) |-> allow);
  // R3
  level_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> level >= $past(level));
  // R4
  full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && level == SEG_FULL && !s_above && !fault) |=> level == SEG_FULL);
endmodule

bind pss_ctrl pss_ctrl_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .active_o(active_o),
  .seg_o   (seg_o),
  .state_q (state_q),
  .level   (level),
  .fault   (fault),
  .s_above (s_above),
  .s_below (s_below),
  .s_short (s_short),
  .allow   (allow)
);

// File: tb/test_pss_ctrl.sv
module test_pss_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 0, uv_i = 0, ot_i = 0, above_i = 0, below_i = 0, short_i = 0;
  logic       active_o;
  logic [1:0] seg_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // model state
  logic [5:0] m_s1 = '0, m_s2 = '0;
  int m_st = 0, m_cnt = 0, m_scc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pss_ctrl i_pss_ctrl (
    .clk_i, .rst_ni, .en_i, .uv_i, .ot_i, .above_i, .below_i, .short_i,
    .active_o, .seg_o
  );

  function automatic logic [1:0] lvl(int c);
    if (c < 3)  return 2'b01;
    if (c < 10) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic exp_act();
    return (m_st == 2) && (!m_s2[5] || m_scc == 0);
  endfunction

  function automatic logic [1:0] exp_seg();
    return exp_act() ? lvl(m_cnt) : 2'b00;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    string tag;
    if (m_st == 0)      tag = "R6";
    else if (m_st == 1) tag = "R1";
    else if (m_s2[5])   tag = "R5";
    else if (m_cnt < 3) tag = "R2";
    else if (m_cnt < 10) tag = "R3";
    else                tag = "R4";
    check({tag, " active"}, {2'b0, active_o}, {2'b0, exp_act()});
    check({tag, " seg"}, {1'b0, seg_o}, {1'b0, exp_seg()});
    check("R7 idle seg", {2'b0, (!active_o && seg_o != 2'b00)}, 3'd0);
  endtask

  task automatic model_step(logic [5:0] v);
    logic flt, hi, lo;
    int nst, ncnt;
    flt = !m_s2[0] | m_s2[1] | m_s2[2];
    hi = m_s2[3];
    lo = m_s2[4];
    nst = m_st;
    if (flt) nst = 0;
    else if (m_st == 0) nst = 1;
    else if (m_st == 1 && lo && !hi) nst = 2;
    else if (m_st == 2 && hi) nst = 1;
    ncnt = (m_st != 2) ? 0 : ((m_cnt < 10) ? m_cnt + 1 : 10);
    m_scc = (m_scc + 1) % 16;
    m_s2 = m_s1;
    m_s1 = v;
    m_st = nst;
    m_cnt = ncnt;
  endtask

  // v bits: 0 en, 1 uv, 2 ot, 3 above, 4 below, 5 short
  task automatic tick(logic [5:0] v);
    check_outputs();
    {short_i, below_i, above_i, ot_i, uv_i, en_i} = v;
    model_step(v);
    @(negedge clk_i);
  endtask

  task automatic hold(logic [5:0] v, int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [5:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 reset active", {2'b0, active_o}, 3'd0);
    check("R9 reset seg", {1'b0, seg_o}, 3'd0);
    rst_ni = 1'b1;
    m_s1 = '0; m_s2 = '0; m_st = 0; m_cnt = 0; m_scc = 0;

    // enable, no limits: goes to skip, stays off
    hold(6'b000001, 6);
    check("R6 skip after fault clear", {1'b0, seg_o}, 3'd0);

    // R8: below asserted, outputs must change only after third edge
    tick(6'b010001);
    check("R8 edge1 still off", {2'b0, active_o}, 3'd0);
    tick(6'b010001);
    check("R8 edge2 still off", {2'b0, active_o}, 3'd0);
    tick(6'b010001);
    check("R8 edge3 quarter on", {1'b0, seg_o}, 3'd1);
    // escalate to full
    hold(6'b000001, 14);
    check("R4 full reached", {1'b0, seg_o}, 3'd3);
    // above -> skip
    hold(6'b001001, 4);
    check("R1 skipped", {2'b0, active_o}, 3'd0);
    // restart at quarter
    hold(6'b010001, 3);
    check("R2 restart quarter", {1'b0, seg_o}, 3'd1);
    hold(6'b000001, 3);
    check("R3 half", {1'b0, seg_o}, 3'd2);
    // R10 both flags
    hold(6'b011001, 8);
    check("R10 both flags off", {2'b0, active_o}, 3'd0);
    // R5 long short run in switching
    hold(6'b110001, 3);
    hold(6'b100001, 64);
    // fault during full
    hold(6'b000001, 10);
    hold(6'b000101, 4);
    check("R6 ot off", {1'b0, seg_o}, 3'd0);
    hold(6'b000011, 4);
    hold(6'b000000, 4);

    // constrained random: hold each pattern a random run
    for (int k = 0; k < 3000; k++) begin
      v[0] = ($urandom_range(0, 19) != 0);
      v[1] = ($urandom_range(0, 29) == 0);
      v[2] = ($urandom_range(0, 29) == 0);
      v[3] = ($urandom_range(0, 3) == 0);
      v[4] = ($urandom_range(0, 2) == 0);
      v[5] = ($urandom_range(0, 7) == 0);
      hold(v, $urandom_range(1, 14));
    end
    finish_run();
  end
endmodule